// File: doc/BRIEF.md
# Condition Code and Branch Sequencer

This block steers program flow in a four-lane vector shader core. It keeps a condition register with one 2-bit code per lane. An instruction rewrites that register from the result flags that the ALU reports, and it does so only when its update flag is set. Each instruction also names a comparison test and a swizzle. The swizzle routes any condition lane to each of the four test positions. When at least one of the swizzled lanes passes the test, the conditional branch, call or return is taken.

The same per-lane test result can also gate result writes. It is ANDed with the instruction's static write mask to give the lane-enable output. A branch target comes either from an immediate field or from a selected lane of the address register. Calls push the return address onto an internal stack four entries deep. A stack overflow, a stack underflow or too many executed instructions stops the program and raises a flag. A start pulse begins a new vertex at address 0.

Top module: `cc_branch_seq`

## Requirements
- R1: After reset the state is as follows: `pc` is 0, `running` is 0 and both error flags are 0. Every condition lane holds EQ (01). With the masking test disabled, `lane_en` equals `wmask`.
- R2: Each lane's code uses this encoding: 00 less than zero, 01 equal to zero, 10 greater than zero, 11 unordered. On an executed instruction the register loads `res_cc` (lane k in bits [2k+1:2k]) only when `cc_upd` is 1. Otherwise it keeps its value.
- R3: Test codes: 0 always, 1 never, 2 EQ, 3 NE, 4 LT, 5 LE, 6 GT, 7 GE. Unordered passes only "always" and NE. Test position k reads lane `cond_swz[2k+1:2k]`. A conditional flow op is taken when any of the four positions passes.
- R4: Flow op encodings: 0 none, 1 branch, 2 call, 3 return, 4 halt. An instruction with op none, or a flow op that is not taken, advances `pc` by one on the next cycle. A taken branch loads its target.
- R5: When `tgt_from_addr` is 1, the target is lane `addr_sel` of `addr_lanes` (lane k in bits [8k+7:8k] for PC_W=8). When it is 0, the target is `tgt_imm`.
- R6: A taken call pushes `pc`+1 and jumps to the target. A taken return pops into `pc`. Calls and returns use the same test, swizzle and target choices as branches. A call that is not taken pushes nothing.
- R7: A call is taken while four return addresses are already stored, or a return is taken with the stack empty. Either case sets `err_stack`, clears `running` and leaves `pc` unchanged.
- R8: With `cmask_en` at 1, `lane_en[k]` equals `wmask[k]` AND the test result at swizzled position k. With `cmask_en` at 0, `lane_en` equals `wmask`.
- R9: The instruction that brings the executed count to EXEC_LIMIT sets `err_limit` and clears `running`.
- R10: A halt op clears `running` and leaves `pc` unchanged. While `running` is 0, `issue` has no effect on `pc`.
- R11: A `start` pulse sets `pc` to 0, empties the stack, clears the count and the error flags, resets all lanes to EQ and sets `running`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new vertex program |
| issue | input | 1 | A decoded instruction is presented this cycle |
| flow_op | input | 3 | Flow operation |
| cond_test | input | 3 | Condition test code |
| cond_swz | input | 8 | Swizzle over the condition lanes |
| tgt_imm | input | PC_W | Immediate target |
| tgt_from_addr | input | 1 | Take the target from an address lane |
| addr_sel | input | 2 | Address lane selector |
| addr_lanes | input | 4*PC_W | Address register lanes |
| cc_upd | input | 1 | Update the condition register |
| res_cc | input | 8 | Condition codes of the result |
| wmask | input | 4 | Static write mask |
| cmask_en | input | 1 | Apply the condition test to the write mask |
| pc | output | PC_W | Program counter |
| lane_en | output | 4 | Effective lane write enable |
| running | output | 1 | Program active |
| err_stack | output | 1 | Call or return stack fault |
| err_limit | output | 1 | Executed-instruction limit reached |

## Verification
The bench builds the block with PC_W=8, DEPTH=4 and EXEC_LIMIT=40. The lowered limit lets the bench reach the executed-instruction stop within a few dozen cycles and probe it at exactly the 39th and 40th instructions. The stack depth is kept at four, so the fifth nested call and the return from an empty stack are exercised as specified. The four address lanes hold distinct fixed values, so a wrong lane select shows up directly in `pc`.

// File: rtl/cc_branch_seq.sv
module cc_branch_seq #(
  parameter int PC_W       = 8,
  parameter int DEPTH      = 4,
  parameter int EXEC_LIMIT = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              issue,
  input  logic [2:0]        flow_op,
  input  logic [2:0]        cond_test,
  input  logic [7:0]        cond_swz,
  input  logic [PC_W-1:0]   tgt_imm,
  input  logic              tgt_from_addr,
  input  logic [1:0]        addr_sel,
  input  logic [4*PC_W-1:0] addr_lanes,
  input  logic              cc_upd,
  input  logic [7:0]        res_cc,
  input  logic [3:0]        wmask,
  input  logic              cmask_en,
  output logic [PC_W-1:0]   pc,
  output logic [3:0]        lane_en,
  output logic              running,
  output logic              err_stack,
  output logic              err_limit
);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(EXEC_LIMIT + 1);
  localparam logic [2:0] OP_BRA = 3'd1, OP_CAL = 3'd2, OP_RET = 3'd3, OP_HLT = 3'd4;
  localparam logic [1:0] C_LT = 2'b00, C_EQ = 2'b01, C_GT = 2'b10;

  logic [7:0]      cc_q;
  logic [DW-1:0]   depth;
  logic [CW-1:0]   cnt;
  logic [PC_W-1:0] stk [DEPTH];
  logic [3:0]      lane_pass;

  function automatic logic tpass(input logic [2:0] t, input logic [1:0] c);
    case (t)
      3'd0: tpass = 1'b1;
      3'd1: tpass = 1'b0;
      3'd2: tpass = (c == C_EQ);
      3'd3: tpass = (c != C_EQ);
      3'd4: tpass = (c == C_LT);
      3'd5: tpass = (c == C_LT) || (c == C_EQ);
      3'd6: tpass = (c == C_GT);
      default: tpass = (c == C_GT) || (c == C_EQ);
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++)
      lane_pass[i] = tpass(cond_test, cc_q[{cond_swz[2*i +: 2], 1'b0} +: 2]);
  end

  assign lane_en = wmask & (cmask_en ? lane_pass : 4'hF);

  wire             take     = |lane_pass;
  wire             exec     = issue && running && !start;
  wire [PC_W-1:0]  pc_inc   = pc + 1'b1;
  wire [PC_W-1:0]  target   = tgt_from_addr ? addr_lanes[addr_sel*PC_W +: PC_W] : tgt_imm;
  wire [DW-1:0]    depth_m1 = depth - 1'b1;
  wire             do_cal   = exec && flow_op == OP_CAL && take;
  wire             do_ret   = exec && flow_op == OP_RET && take;
  wire             ovf      = do_cal && depth == DW'(DEPTH);
  wire             unf      = do_ret && depth == '0;
  wire             cnt_hit  = exec && cnt == CW'(EXEC_LIMIT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; cc_q <= 8'b01010101; depth <= '0; cnt <= '0;
      running <= 1'b0; err_stack <= 1'b0; err_limit <= 1'b0;
    end else if (start) begin
      pc <= '0; cc_q <= 8'b01010101; depth <= '0; cnt <= '0;
      running <= 1'b1; err_stack <= 1'b0; err_limit <= 1'b0;
    end else if (exec) begin
      cnt <= cnt + 1'b1;
      if (cc_upd) cc_q <= res_cc;
      if (ovf || unf) begin
        err_stack <= 1'b1;
        running   <= 1'b0;
      end else if (flow_op == OP_HLT) begin
        running <= 1'b0;
      end else if (do_cal) begin
        stk[depth[SW-1:0]] <= pc_inc;
        depth <= depth + 1'b1;
        pc    <= target;
      end else if (do_ret) begin
        pc    <= stk[depth_m1[SW-1:0]];
        depth <= depth_m1;
      end else if (flow_op == OP_BRA && take) begin
        pc <= target;
      end else begin
        pc <= pc_inc;
      end
      if (cnt_hit) begin
        err_limit <= 1'b1;
        running   <= 1'b0;
      end
    end
  end

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) depth <= DW'(DEPTH));
  // R7
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n) (err_stack || err_limit) |-> !running);
  // R2
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(exec && cc_upd)) |=> $stable(cc_q));
  // R10
  idle_pc_chk: assert property (@(posedge clk) disable iff (!rst_n) (!running && !start) |=> $stable(pc));
  // R8
  lane_sub_chk: assert property (@(posedge clk) disable iff (!rst_n) (lane_en & ~wmask) == 4'b0);
  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(EXEC_LIMIT));
endmodule

// File: tb/cc_branch_seq_test.sv
`timescale 1ns/100ps
module cc_branch_seq_test;
  logic clk = 0, rst_n = 0, start = 0, issue = 0;
  logic [2:0] flow_op = 0, cond_test = 0;
  logic [7:0] cond_swz = 8'b11100100, tgt_imm = 0, res_cc = 0;
  logic tgt_from_addr = 0, cc_upd = 0, cmask_en = 0;
  logic [1:0] addr_sel = 0;
  logic [31:0] addr_lanes = {8'd200, 8'd150, 8'd100, 8'd50};
  logic [3:0] wmask = 4'hF;
  logic [7:0] pc;
  logic [3:0] lane_en;
  logic running, err_stack, err_limit;
  int checks = 0, errors = 0;
  bit done = 0;

  cc_branch_seq #(.PC_W(8), .DEPTH(4), .EXEC_LIMIT(40)) uut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic instr(input logic [2:0] op, input logic [2:0] t, input logic [7:0] s,
                       input logic [7:0] tg, input logic fa, input logic [1:0] as,
                       input logic up, input logic [7:0] rc);
    @(negedge clk);
    flow_op = op; cond_test = t; cond_swz = s; tgt_imm = tg; tgt_from_addr = fa;
    addr_sel = as; cc_upd = up; res_cc = rc; issue = 1;
    @(posedge clk); #1;
    issue = 0; cc_upd = 0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1;
    @(posedge clk); #1; start = 0;
  endtask

  task automatic t_reset();
    chk("R1 pc", pc, 0);
    chk("R1 running", running, 0);
    chk("R1 errors", {err_stack, err_limit}, 0);
    chk("R1 lane_en=wmask", lane_en, 4'hF);
    cmask_en = 1; cond_test = 3'd2; #1;
    chk("R1 reset lanes EQ", lane_en, 4'hF);
    cmask_en = 0; cond_test = 0;
  endtask

  task automatic t_seq();
    do_start();
    chk("R11 start running", running, 1);
    chk("R11 start pc", pc, 0);
    for (int i = 1; i <= 3; i++) begin
      instr(0, 0, 8'b11100100, 0, 0, 0, 0, 0);
      chk("R4 sequential pc", pc, i);
    end
  endtask

  task automatic t_cc();
    instr(0, 0, 8'b11100100, 0, 0, 0, 0, 8'hAA);
    cmask_en = 1; cond_swz = 8'b11100100; cond_test = 3'd2; #1;
    chk("R2 no update holds EQ", lane_en, 4'hF);
    instr(0, 0, 8'b11100100, 0, 0, 0, 1, 8'b11100100);
    cond_swz = 8'b11100100;
    cond_test = 3'd4; #1; chk("R2 R8 LT lanes", lane_en, 4'b0001);
    cond_test = 3'd2; #1; chk("R2 R8 EQ lanes", lane_en, 4'b0010);
    cond_test = 3'd6; #1; chk("R2 R8 GT lanes", lane_en, 4'b0100);
    cond_test = 3'd3; #1; chk("R3 NE incl unordered", lane_en, 4'b1101);
    cond_test = 3'd5; #1; chk("R3 LE", lane_en, 4'b0011);
    cond_test = 3'd7; #1; chk("R3 GE", lane_en, 4'b0110);
    cond_test = 3'd0; #1; chk("R3 always", lane_en, 4'b1111);
    cond_test = 3'd1; #1; chk("R3 never", lane_en, 4'b0000);
    wmask = 4'b1010; cond_test = 3'd3; #1; chk("R8 AND static mask", lane_en, 4'b1000);
    wmask = 4'hF; cond_swz = 8'b10101010; cond_test = 3'd6; #1;
    chk("R3 R8 swizzle replicate", lane_en, 4'b1111);
    cmask_en = 0; cond_test = 3'd1; #1; chk("R8 mask disabled", lane_en, 4'hF);
  endtask

  task automatic t_bra();
    logic [7:0] p;
    p = pc;
    instr(1, 3'd2, 8'b00000000, 8'd20, 0, 0, 0, 0);
    chk("R3 R4 branch not taken", pc, p + 1);
    instr(1, 3'd2, 8'b11100100, 8'd20, 0, 0, 0, 0);
    chk("R3 branch any lane taken", pc, 20);
    instr(1, 3'd1, 8'b11100100, 8'd99, 0, 0, 0, 0);
    chk("R3 never not taken", pc, 21);
    instr(1, 3'd0, 8'b11100100, 8'd30, 0, 0, 0, 0);
    chk("R4 unconditional", pc, 30);
    instr(1, 3'd0, 8'b11100100, 8'd5, 1, 2, 0, 0);
    chk("R5 computed lane2", pc, 150);
    instr(1, 3'd0, 8'b11100100, 8'd5, 1, 3, 0, 0);
    chk("R5 computed lane3", pc, 200);
  endtask

  task automatic t_call();
    instr(2, 3'd0, 8'b11100100, 8'd10, 0, 0, 0, 0);
    chk("R6 call jumps", pc, 10);
    instr(2, 3'd2, 8'b00000000, 8'd77, 0, 0, 0, 0);
    chk("R6 call not taken", pc, 11);
    instr(2, 3'd0, 8'b11100100, 8'd0, 1, 0, 0, 0);
    chk("R6 R5 computed call", pc, 50);
    instr(3, 3'd1, 8'b11100100, 0, 0, 0, 0, 0);
    chk("R6 return not taken", pc, 51);
    instr(3, 3'd0, 8'b11100100, 0, 0, 0, 0, 0);
    chk("R6 return inner", pc, 12);
    instr(3, 3'd0, 8'b11100100, 0, 0, 0, 0, 0);
    chk("R6 return outer", pc, 201);
  endtask

  task automatic t_nest();
    logic [7:0] tg [4] = '{8'd60, 8'd70, 8'd80, 8'd90};
    for (int i = 0; i < 4; i++) begin
      instr(2, 3'd0, 8'b11100100, tg[i], 0, 0, 0, 0);
      chk("R6 nested call", pc, tg[i]);
    end
    chk("R7 four levels ok", {running, err_stack}, 2'b10);
    instr(2, 3'd0, 8'b11100100, 8'd111, 0, 0, 0, 0);
    chk("R7 fifth call err", {running, err_stack}, 2'b01);
    chk("R7 pc held on overflow", pc, 90);
    instr(0, 0, 8'b11100100, 0, 0, 0, 0, 0);
    chk("R10 issue ignored when stopped", pc, 90);
    do_start();
    chk("R11 restart clears", {running, err_stack, err_limit, pc}, {3'b100, 8'd0});
    instr(3, 3'd0, 8'b11100100, 0, 0, 0, 0, 0);
    chk("R7 empty return err", {running, err_stack}, 2'b01);
    chk("R7 pc held on underflow", pc, 0);
  endtask

  task automatic t_halt();
    do_start();
    instr(0, 0, 8'b11100100, 0, 0, 0, 0, 0);
    instr(4, 0, 8'b11100100, 0, 0, 0, 0, 0);
    chk("R10 halt stops", {running, err_stack, err_limit}, 3'b000);
    chk("R10 halt pc held", pc, 1);
    instr(1, 3'd0, 8'b11100100, 8'd44, 0, 0, 0, 0);
    chk("R10 branch ignored after halt", pc, 1);
  endtask

  task automatic t_limit();
    do_start();
    for (int i = 0; i < 39; i++) instr(0, 0, 8'b11100100, 0, 0, 0, 0, 0);
    chk("R9 below limit", {running, err_limit}, 2'b10);
    chk("R9 pc at 39", pc, 39);
    instr(0, 0, 8'b11100100, 0, 0, 0, 0, 0);
    chk("R9 limit reached", {running, err_limit}, 2'b01);
    chk("R9 pc at 40", pc, 40);
    instr(0, 0, 8'b11100100, 0, 0, 0, 0, 0);
    chk("R9 R10 stopped after limit", pc, 40);
  endtask

  initial begin
    #12 @(negedge clk);
    t_reset();
    rst_n = 1;
    t_seq();
    t_cc();
    t_bra();
    t_call();
    t_nest();
    t_halt();
    t_limit();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule